// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked chain of 16-byte region descriptors held in local memory. A start pulse hands it the byte address of the first descriptor. For each descriptor it reads four 32-bit words and decodes the buffer address, the length, the direction, the ordering hint and the transfer mode. It then presents one transfer request to a data mover and holds that request until the mover acknowledges it. After the acknowledge, the walker either follows the descriptor's next pointer or finishes.

A walk ends in one of three ways. A descriptor with its end flag set produces a completion pulse. A zero-length descriptor produces an error pulse, and no transfer is issued for it. If a configurable number of descriptors has been handled without any end flag, a limit error pulse is produced. The block moves no data itself; the mover is responsible for bus timing and byte movement.

Top module: `prd_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `xfer_req`, `done`, `err_zero_len` and `err_limit` are all low.
- R2: Descriptor words are read at the descriptor base plus 0, 4, 8 and 12, and are decoded as follows. Word 0 is the buffer address. Word 1 is the length in 8-byte units. Word 2 bits [7:0] are the flags: bit 4 means ordered, bit 5 means write (host to device), and bit 7 means end. Word 2 bits [11:8] are the transfer mode; bits [15:12] and [31:16] are ignored. Word 3 is the next pointer.
- R3: While fetching, `mem_req` is held high with a stable `mem_addr` until `mem_ack`. For a chain without an end flag before its last descriptor, one transfer is issued per descriptor, in chain order, by following each next pointer.
- R4: When the current descriptor has its end flag set, the walker pulses `done` for one cycle after the transfer acknowledge and returns to idle. Its next pointer is ignored, and no further descriptor words are fetched.
- R5: No descriptor fetch overlaps a pending transfer request. The next descriptor is read only after `xfer_ack`.
- R6: A descriptor whose length is zero pulses `err_zero_len`, issues no transfer, and stops the walk.
- R7: After MAX_DESC transfers in one walk without an end flag, the walker pulses `err_limit` and stops without fetching further.
- R8: A `start` pulse that arrives while `busy` is high is ignored.
- R9: While `xfer_req` is high and not yet acknowledged, `xfer_req` stays high and all transfer fields stay stable.
- R10: `busy` rises on the cycle after an accepted `start` and is low whenever `done`, `err_zero_len` or `err_limit` is high. At most one of those three pulses is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `start_ptr` |
| start_ptr | input | ADDR_W | Byte address of first descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: chain finished at end flag |
| err_zero_len | output | 1 | One-cycle pulse: zero-length descriptor |
| err_limit | output | 1 | One-cycle pulse: descriptor limit reached |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the word requested |
| mem_ack | input | 1 | Read accepted, `mem_rdata` valid |
| mem_rdata | input | 32 | Descriptor word read data |
| xfer_req | output | 1 | Transfer request to data mover |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | LEN_W | Length in 8-byte units |
| xfer_write | output | 1 | 1 = host to device |
| xfer_ordered | output | 1 | Ordered transfer hint |
| xfer_mode | output | 4 | Transfer mode |
| xfer_ack | input | 1 | Transfer request accepted |

## Verification
The bench builds the walker with MAX_DESC set to 4 and 32-bit addresses and lengths. The small limit makes the limit error reachable with a single descriptor that points back to itself. The memory model answers one word per cycle, while the data mover model waits a programmable number of cycles. A long mover delay holds the walker in the transfer state long enough to inject a stray start pulse and to check that no fetch overlaps the pending request.

// File: rtl/prd_walker.sv
module prd_walker #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 32,
  parameter int MAX_DESC = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_ptr,
  output logic              busy,
  output logic              done,
  output logic              err_zero_len,
  output logic              err_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_write,
  output logic              xfer_ordered,
  output logic [3:0]        xfer_mode,
  input  logic              xfer_ack
);

  localparam int CNT_W   = $clog2(MAX_DESC + 1);
  localparam int F_ORDER = 4;
  localparam int F_WRITE = 5;
  localparam int F_END   = 7;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_t;

  state_t            state;
  logic [ADDR_W-1:0] ptr, next_q;
  logic [1:0]        widx;
  logic [7:0]        flags_q;
  logic [CNT_W-1:0]  cnt;

  assign busy         = (state != S_IDLE);
  assign mem_req      = (state == S_FETCH);
  assign mem_addr     = ptr + ADDR_W'({widx, 2'b00});
  assign xfer_req     = (state == S_XFER);
  assign xfer_write   = flags_q[F_WRITE];
  assign xfer_ordered = flags_q[F_ORDER];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      ptr          <= '0;
      next_q       <= '0;
      widx         <= '0;
      flags_q      <= '0;
      cnt          <= '0;
      xfer_addr    <= '0;
      xfer_len     <= '0;
      xfer_mode    <= '0;
      done         <= 1'b0;
      err_zero_len <= 1'b0;
      err_limit    <= 1'b0;
    end else begin
      done         <= 1'b0;
      err_zero_len <= 1'b0;
      err_limit    <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ptr   <= start_ptr;
          widx  <= '0;
          cnt   <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (widx)
            2'd0: xfer_addr <= mem_rdata[ADDR_W-1:0];
            2'd1: xfer_len  <= mem_rdata[LEN_W-1:0];
            2'd2: begin
              flags_q   <= mem_rdata[7:0];
              xfer_mode <= mem_rdata[11:8];
            end
            default: next_q <= mem_rdata[ADDR_W-1:0];
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) begin
            if (xfer_len == '0) begin
              err_zero_len <= 1'b1;
              state        <= S_IDLE;
            end else begin
              state <= S_XFER;
            end
          end
        end
        S_XFER: if (xfer_ack) begin
          cnt  <= cnt + 1'b1;
          widx <= '0;
          if (flags_q[F_END]) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (cnt == CNT_W'(MAX_DESC - 1)) begin
            err_limit <= 1'b1;
            state     <= S_IDLE;
          end else begin
            ptr   <= next_q;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 32,
  parameter int MAX_DESC = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err_zero_len,
  input logic              err_limit,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              xfer_req,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_write,
  input logic              xfer_ordered,
  input logic [3:0]        xfer_mode,
  input logic              xfer_ack
);

  localparam int CW = $clog2(MAX_DESC + 1) + 1;
  logic [CW-1:0] acks;

  always_ff @(posedge clk) begin
    if (!rst_n)                 acks <= '0;
    else if (start && !busy)    acks <= '0;
    else if (xfer_req && xfer_ack) acks <= acks + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !mem_req && !xfer_req);

  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));

  assert_limit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_limit |-> acks == CW'(MAX_DESC));

  assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len)
      && $stable(xfer_write) && $stable(xfer_ordered) && $stable(xfer_mode));

  assert_idle_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_zero_len || err_limit) |-> !busy);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_zero_len, err_limit}));

endmodule

bind prd_walker prd_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_DESC(MAX_DESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_zero_len(err_zero_len), .err_limit(err_limit), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .xfer_req(xfer_req),
  .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_write(xfer_write),
  .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode), .xfer_ack(xfer_ack)
);

// File: tb/prd_walker_test.sv
`timescale 1ns/1ps
module prd_walker_test;
  localparam int MAXD = 4;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_ptr = 0;
  logic        busy, done, err_zero_len, err_limit;
  logic        mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        xfer_req, xfer_ack = 0, xfer_write, xfer_ordered;
  logic [31:0] xfer_addr, xfer_len;
  logic [3:0]  xfer_mode;

  prd_walker #(.ADDR_W(32), .LEN_W(32), .MAX_DESC(MAXD)) uut (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] lg_addr [0:15];
  logic [31:0] lg_len  [0:15];
  logic [5:0]  lg_misc [0:15];
  int n_xfer, n_fetch, n_overlap, xdelay, wcnt;
  int checks = 0, fails = 0;
  int outcome; // 0 none, 1 done, 2 zero, 3 limit

  always @(negedge clk) begin
    if (mem_req) begin
      mem_ack   <= 1;
      mem_rdata <= mem[mem_addr[9:2]];
      n_fetch++;
      if (xfer_req) n_overlap++;
    end else mem_ack <= 0;
    if (xfer_req && !xfer_ack) begin
      if (wcnt >= xdelay) begin
        xfer_ack <= 1;
        wcnt = 0;
        if (n_xfer < 16) begin
          lg_addr[n_xfer] = xfer_addr;
          lg_len[n_xfer]  = xfer_len;
          lg_misc[n_xfer] = {xfer_write, xfer_ordered, xfer_mode};
        end
        n_xfer++;
      end else wcnt++;
    end else xfer_ack <= 0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int base, logic [31:0] a, logic [31:0] l, logic [31:0] w2, logic [31:0] nx);
    mem[base/4] = a; mem[base/4+1] = l; mem[base/4+2] = w2; mem[base/4+3] = nx;
  endtask

  task automatic walk(logic [31:0] ptr, int dly);
    xdelay = dly; wcnt = 0; n_xfer = 0; n_fetch = 0; n_overlap = 0; outcome = 0;
    @(negedge clk); start = 1; start_ptr = ptr;
    @(negedge clk); start = 0;
    chk("R10 busy after start", {31'b0, busy}, 1);
    for (int i = 0; i < 2000 && outcome == 0; i++) begin
      if (done) outcome = 1;
      else if (err_zero_len) outcome = 2;
      else if (err_limit) outcome = 3;
      else @(negedge clk);
    end
    if (outcome == 0) begin fails++; checks++; $display("FAIL watchdog walk timeout"); end
    @(negedge clk);
    chk("R10 idle after end", {31'b0, busy}, 0);
  endtask

  task t_reset;
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 reqs", {30'b0, mem_req, xfer_req}, 0);
    chk("R1 pulses", {29'b0, done, err_zero_len, err_limit}, 0);
  endtask

  task t_single; // R2 R4
    put(32'h40, 32'h1000_0008, 5, 32'h0007_F4B0, 32'h0000_0200);
    put(32'h200, 32'h7777_0000, 9, 32'h0000_0080, 0);
    walk(32'h40, 0);
    chk("R4 outcome done", outcome, 1);
    chk("R4 next ignored, xfers", n_xfer, 1);
    chk("R4 no extra fetch", n_fetch, 4);
    chk("R2 addr", lg_addr[0], 32'h1000_0008);
    chk("R2 len", lg_len[0], 5);
    chk("R2 write/ordered/mode", {26'b0, lg_misc[0]}, 6'b11_0100);
  endtask

  task t_chain; // R3 R5
    put(32'h80,  32'hA000_0000, 3, 32'h0000_0200, 32'h100);
    put(32'h100, 32'hB000_0000, 7, 32'h0000_0510, 32'h20);
    put(32'h20,  32'hC000_0000, 1, 32'h0000_0AA0, 0);
    walk(32'h80, 3);
    chk("R3 outcome", outcome, 1);
    chk("R3 count", n_xfer, 3);
    chk("R3 order 0", lg_addr[0], 32'hA000_0000);
    chk("R3 order 1", lg_addr[1], 32'hB000_0000);
    chk("R3 order 2", lg_addr[2], 32'hC000_0000);
    chk("R2 d0 read unordered mode2", {26'b0, lg_misc[0]}, 6'b00_0010);
    chk("R2 d1 ordered mode5", {26'b0, lg_misc[1]}, 6'b01_0101);
    chk("R2 d2 write mode10", {26'b0, lg_misc[2]}, 6'b10_1010);
    chk("R2 len 1", lg_len[1], 7);
    chk("R5 no fetch during transfer", n_overlap, 0);
    chk("R3 fetch words", n_fetch, 12);
  endtask

  task t_zero; // R6
    put(32'h140, 32'hD000_0000, 2, 32'h0, 32'h180);
    put(32'h180, 32'hE000_0000, 0, 32'h0, 32'h1C0);
    put(32'h1C0, 32'hF000_0000, 2, 32'h80, 0);
    walk(32'h140, 1);
    chk("R6 outcome", outcome, 2);
    chk("R6 no transfer for zero", n_xfer, 1);
    chk("R6 walk stopped", n_fetch, 8);
  endtask

  task t_limit; // R7
    put(32'h380, 32'h5500_0000, 4, 32'h0000_0010, 32'h380);
    walk(32'h380, 0);
    chk("R7 outcome", outcome, 3);
    chk("R7 transfers", n_xfer, MAXD);
    chk("R7 no fetch beyond", n_fetch, 4 * MAXD);
  endtask

  task t_busy_start; // R8
    put(32'h240, 32'h1100_0000, 2, 32'h0, 32'h280);
    put(32'h280, 32'h2200_0000, 2, 32'h80, 0);
    put(32'h300, 32'hBAD0_0000, 2, 32'h80, 0);
    fork
      walk(32'h240, 6);
      begin
        repeat (8) @(negedge clk);
        start = 1; start_ptr = 32'h300;
        @(negedge clk); start = 0;
      end
    join
    chk("R8 outcome", outcome, 1);
    chk("R8 count", n_xfer, 2);
    chk("R8 first", lg_addr[0], 32'h1100_0000);
    chk("R8 second", lg_addr[1], 32'h2200_0000);
    repeat (3) @(negedge clk);
    chk("R8 no late walk", {31'b0, busy}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_zero();
    t_limit();
    t_busy_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule